// File: doc/BRIEF.md
# Streaming 2D Convolution Filter with Line Memories

This block filters a raster video stream with a square K x K kernel. Pixels enter one per beat in raster order on a valid/ready input. Each new pixel is written into a cascade of K-1 on-chip line memories, and each memory holds one full image line. The incoming pixel and the K-1 stored pixels at the same column form one vertical column of the neighbourhood. A bank of K column registers turns these columns into the full window. No pixel is ever read back from external frame memory.

Each output is the new value of the window's centre pixel. It is a weighted sum of the K x K neighbourhood. The kernel is point-symmetric about its centre, so the two pixels that share a weight are added first and then meet a single multiplier. This gives (K*K+1)/2 multipliers instead of K*K. The full-precision sum is scaled down by a programmable right shift, rounded half-up and clamped to the pixel range.

At the image edges, missing neighbours are filled by repeating the nearest edge pixel. To do this the block runs (K-1)/2 extra internal steps at the end of every line, and (K-1)/2 extra lines at the end of every frame. During these steps it holds s_ready low.

Back-pressure rules:
- A beat transfers on either side only when valid and ready are both high in the same cycle.
- While m_valid is high and m_ready is low, the whole pipeline is frozen and s_ready is low.
- s_valid may drop at any time without harm.

Top module: `img_conv2d`

## Requirements
- R1: After reset the active kernel is the identity: centre weight 1, all other weights 0, shift 0. A frame filtered with it comes out equal to the input frame.
- R2: For output position (x,y), the result is the sum over dy,dx in [-H,H] of w(dy,dx) * P(clampy(y+dy), clampx(x+dx)), where H=(K-1)/2. Coordinates outside the image are clamped to the nearest edge row or column.
- R3: Let n = (dy+H)*K + (dx+H). A write to cfg_addr = a, with a < (K*K+1)/2, sets the weight of taps n = a and n = K*K-1-a. The weight is a signed two's complement value of CW bits. A write to cfg_addr = (K*K+1)/2 sets the shift from the low SW bits of cfg_data. Other addresses have no effect.
- R4: With shift s, the result is floor((sum + 2^(s-1)) / 2^s), or the plain sum when s = 0. It is then clamped to the range 0 to 2^PW-1, which is 0 to 4095 for 12-bit pixels.
- R5: Weights and shift written during a frame do not affect that frame. They take effect from the first accepted pixel of the next frame.
- R6: Exactly one output is produced per input pixel, in raster order. m_sof marks the first output of a frame, and m_sol marks the first output of every line. After reset, m_valid is low.
- R7: When a frame is expected, a beat without s_sof is accepted and discarded. s_sof on other beats is ignored, and s_sol is ignored everywhere.
- R8: While m_valid is high and m_ready is low, m_data, m_sof and m_sol hold their values and s_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept an input pixel |
| s_data | input | PW | Input pixel |
| s_sof | input | 1 | Input start of frame |
| s_sol | input | 1 | Input start of line (ignored) |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream can accept |
| m_data | output | PW | Filtered pixel |
| m_sof | output | 1 | Output start of frame |
| m_sol | output | 1 | Output start of line |
| cfg_we | input | 1 | Coefficient register write strobe |
| cfg_addr | input | AW | Weight index, or (K*K+1)/2 for the shift |
| cfg_data | input | CW | Write data |

## Verification
The filter is driven with four kinds of image:
- Random-pixel frames under the identity kernel show that the window lag and the marker alignment are right before any arithmetic is involved.
- A single bright impulse on a dark field, filtered with a kernel whose weights all differ, paints the kernel itself into the output. This separates a correct tap-to-address mapping from a mirrored or transposed one, and shows edge replication wherever the impulse meets a border.
- A gradient frame under a heavy all-ones kernel drives part of the image into the upper clamp.
- Signed weights on random frames reach the lower clamp and exercise half-up rounding.

Random output stalls, input gaps, stray marker beats and a coefficient rewrite in mid-frame check that the result does not depend on the timing of the stream.

// File: rtl/img_conv2d_pkg.sv
package img_conv2d_pkg;

  // Number of distinct weights of a point-symmetric KxK kernel.
  function automatic int tap_pairs(input int k);
    return (k * k + 1) / 2;
  endfunction

  // Accumulator width: pair sum, sign bit, weight, growth of the adder tree.
  function automatic int acc_width(input int pw, input int cw, input int k);
    return pw + 2 + cw + $clog2(tap_pairs(k)) + 1;
  endfunction

endpackage

// File: rtl/img_conv2d_linebuf.sv
// Cascade of line memories: memory g holds the line that lies g+1 lines above
// the current one. A write pushes every entry of the column down one memory.
module img_conv2d_linebuf #(
  parameter int PW    = 12,
  parameter int LEN   = 256,
  parameter int LINES = 4,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [PW-1:0]       din,
  output logic [LINES*PW-1:0] taps
);

  logic [PW-1:0] rd [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [PW-1:0] mem [LEN];

    assign rd[g] = mem[addr];
    assign taps[g*PW +: PW] = rd[g];

    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (we) mem[addr] <= rd[g-1];
      end
    end
  end

endmodule

// File: rtl/img_conv2d_window.sv
// K column registers; column 0 is the newest. When load is low, the newest
// column is repeated (right-edge replication).
module img_conv2d_window #(
  parameter int PW = 12,
  parameter int K  = 5
) (
  input  logic                clk,
  input  logic                en,
  input  logic                load,
  input  logic [K*PW-1:0]     col,
  output logic [K*K*PW-1:0]   win
);

  logic [K*PW-1:0] cols [K];

  always_ff @(posedge clk) begin
    if (en) begin
      if (load) cols[0] <= col;
      for (int j = 1; j < K; j++) cols[j] <= cols[j-1];
    end
  end

  for (genvar j = 0; j < K; j++) begin : g_out
    assign win[j*K*PW +: K*PW] = cols[j];
  end

endmodule

// File: rtl/img_conv2d_mac.sv
// Three stages: left-edge clamp and symmetric pre-add, multiply and sum,
// then shift with rounding and clamping. One enable freezes all stages.
module img_conv2d_mac import img_conv2d_pkg::*; #(
  parameter int PW = 12,
  parameter int K  = 5,
  parameter int CW = 12,
  parameter int SW = 5,
  parameter int XW = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           in_ok,
  input  logic                           in_sof,
  input  logic                           in_sol,
  input  logic [XW-1:0]                  sx,
  input  logic [K*K*PW-1:0]              win,
  input  logic [tap_pairs(K)*CW-1:0]     coef,
  input  logic [SW-1:0]                  shift,
  output logic                           out_valid,
  output logic [PW-1:0]                  out_data,
  output logic                           out_sof,
  output logic                           out_sol,
  output logic                           busy
);

  localparam int NT   = K * K;
  localparam int NC   = tap_pairs(K);
  localparam int SUMW = PW + 1;
  localparam int PRW  = SUMW + 1 + CW;
  localparam int ACCW = acc_width(PW, CW, K);

  // Stage 1: clamp on the left edge, fold symmetric pairs.
  logic [PW-1:0]   tap  [NT];
  logic [SUMW-1:0] fold [NC];
  logic [SUMW-1:0] s1   [NC];
  logic            v1, sof1, sol1;

  always_comb begin
    for (int i = 0; i < K; i++) begin
      for (int j = 0; j < K; j++) begin
        int sel;
        sel = (int'(sx) < j) ? int'(sx) : j;
        tap[i*K + j] = win[(sel*K + i)*PW +: PW];
      end
    end
    for (int p = 0; p < NC; p++) begin
      if (p == NC - 1) fold[p] = SUMW'(tap[p]);
      else             fold[p] = SUMW'(tap[p]) + SUMW'(tap[NT-1-p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; sof1 <= 1'b0; sol1 <= 1'b0;
    end else if (en) begin
      v1 <= in_ok; sof1 <= in_sof; sol1 <= in_sol;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int p = 0; p < NC; p++) s1[p] <= fold[p];
    end
  end

  // Stage 2: one multiplier per distinct weight, full-precision sum.
  logic signed [ACCW-1:0] acc_c, acc2;
  logic                   v2, sof2, sol2;

  always_comb begin
    acc_c = '0;
    for (int p = 0; p < NC; p++) begin
      logic signed [PRW-1:0] prod;
      prod  = $signed({1'b0, s1[p]}) * $signed(coef[p*CW +: CW]);
      acc_c = acc_c + ACCW'(prod);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; sof2 <= 1'b0; sol2 <= 1'b0; acc2 <= '0;
    end else if (en) begin
      v2 <= v1; sof2 <= sof1; sol2 <= sol1; acc2 <= acc_c;
    end
  end

  // Stage 3: shift with half-up rounding, clamp to the pixel range.
  logic signed [ACCW:0] bias, rnd, shd;
  logic [PW-1:0]        pix;

  always_comb begin
    bias = (shift == '0) ? '0 : ((ACCW+1)'(1) <<< (shift - 1'b1));
    rnd  = {acc2[ACCW-1], acc2} + bias;
    shd  = rnd >>> shift;
    if (shd[ACCW])              pix = '0;
    else if (|shd[ACCW-1:PW])   pix = '1;
    else                        pix = shd[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_sol <= 1'b0; out_data <= '0;
    end else if (en) begin
      out_valid <= v2; out_sof <= sof2; out_sol <= sol2; out_data <= pix;
    end
  end

  assign busy = v1 | v2;

endmodule

// File: rtl/img_conv2d.sv
module img_conv2d import img_conv2d_pkg::*; #(
  parameter int PW        = 12,
  parameter int LINE_LEN  = 256,
  parameter int NUM_LINES = 240,
  parameter int K         = 5,
  parameter int CW        = 12,
  parameter int SW        = 5,
  localparam int AW       = $clog2(tap_pairs(K) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_data,
  input  logic          s_sof,
  input  logic          s_sol,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_data,
  output logic          m_sof,
  output logic          m_sol,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_data
);

  localparam int H   = (K - 1) / 2;
  localparam int NC  = tap_pairs(K);
  localparam int XW  = $clog2(LINE_LEN + H);
  localparam int YW  = $clog2(NUM_LINES + H);
  localparam int LBW = $clog2(LINE_LEN);

  // Scan over the padded grid: LINE_LEN+H steps per line, NUM_LINES+H lines.
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic x_live, y_live, at_start, adv, busy_mac, busy, accept, drop, step;
  logic ov0, sof0, sol0;
  logic [XW-1:0] sx;

  assign x_live   = x < XW'(LINE_LEN);
  assign y_live   = y < YW'(NUM_LINES);
  assign at_start = (x == '0) && (y == '0);
  assign adv      = !m_valid || m_ready;
  assign busy     = ov0 | busy_mac;
  assign s_ready  = adv && x_live && y_live && !(at_start && busy);
  assign accept   = s_valid && s_ready;
  assign drop     = accept && at_start && !s_sof;
  assign step     = adv && ((x_live && y_live) ? (accept && !drop) : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (step) begin
      if (x == XW'(LINE_LEN + H - 1)) begin
        x <= '0;
        y <= (y == YW'(NUM_LINES + H - 1)) ? '0 : y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

  // Line memories; in the bottom padding lines the last line is fed back.
  logic [(K-1)*PW-1:0] taps;
  logic [PW-1:0]       din;
  logic [PW-1:0]       raw [K];
  logic [K*PW-1:0]     vcol;

  assign din = y_live ? s_data : taps[PW-1:0];

  img_conv2d_linebuf #(.PW(PW), .LEN(LINE_LEN), .LINES(K-1), .AW(LBW)) u_lines (
    .clk (clk),
    .we  (step && x_live),
    .addr(x[LBW-1:0]),
    .din (din),
    .taps(taps)
  );

  // Top-edge clamp: rows above the first line take the first line.
  always_comb begin
    raw[0] = din;
    for (int i = 1; i < K; i++) raw[i] = taps[(i-1)*PW +: PW];
    for (int i = 0; i < K; i++) begin
      int src;
      src = (int'(y) < i) ? int'(y) : i;
      vcol[i*PW +: PW] = raw[src];
    end
  end

  logic [K*K*PW-1:0] win;

  img_conv2d_window #(.PW(PW), .K(K)) u_win (
    .clk (clk),
    .en  (step),
    .load(x_live),
    .col (vcol),
    .win (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov0 <= 1'b0; sof0 <= 1'b0; sol0 <= 1'b0; sx <= '0;
    end else if (adv) begin
      ov0  <= step && (x >= XW'(H)) && (y >= YW'(H));
      sof0 <= (x == XW'(H)) && (y == YW'(H));
      sol0 <= (x == XW'(H));
      sx   <= x;
    end
  end

  // Weights: written into a staging copy, moved to the working copy at the
  // first step of a frame (only taken while the pipeline is empty).
  logic [CW-1:0]      stage_w [NC];
  logic [SW-1:0]      stage_s;
  logic [NC*CW-1:0]   work_w;
  logic [SW-1:0]      work_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NC; n++) begin
        stage_w[n]          <= (n == NC - 1) ? CW'(1) : '0;
        work_w[n*CW +: CW]  <= (n == NC - 1) ? CW'(1) : '0;
      end
      stage_s <= '0;
      work_s  <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_addr == AW'(NC))     stage_s <= cfg_data[SW-1:0];
        else if (cfg_addr < AW'(NC)) stage_w[cfg_addr] <= cfg_data;
      end
      if (step && at_start) begin
        for (int n = 0; n < NC; n++) work_w[n*CW +: CW] <= stage_w[n];
        work_s <= stage_s;
      end
    end
  end

  img_conv2d_mac #(.PW(PW), .K(K), .CW(CW), .SW(SW), .XW(XW)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (adv),
    .in_ok    (ov0),
    .in_sof   (sof0),
    .in_sol   (sol0),
    .sx       (sx),
    .win      (win),
    .coef     (work_w),
    .shift    (work_s),
    .out_valid(m_valid),
    .out_data (m_data),
    .out_sof  (m_sof),
    .out_sol  (m_sol),
    .busy     (busy_mac)
  );

  logic unused_ok;
  assign unused_ok = s_sol;

endmodule

// File: rtl/img_conv2d_chk.sv
module img_conv2d_chk #(
  parameter int PW       = 12,
  parameter int LINE_LEN = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [PW-1:0] m_data,
  input logic          m_sof,
  input logic          m_sol
);

  localparam int CNW = $clog2(LINE_LEN + 2);

  logic           beat, seen;
  logic [CNW-1:0] cnt;

  assign beat = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (beat) begin
      if (m_sol) begin
        cnt  <= CNW'(1);
        seen <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: every line holds exactly LINE_LEN outputs
  p_line_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat && m_sol && seen |-> cnt == CNW'(LINE_LEN));

  // R6: no output beyond the line length before the next line start
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !m_sol |-> seen && (cnt < CNW'(LINE_LEN)));

  // R6: a frame start is also a line start
  p_sof_sol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sof |-> m_sol);

  // R8: a stalled output holds its value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_sol));

  // R8: a stalled output blocks the input
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

endmodule

bind img_conv2d img_conv2d_chk #(.PW(PW), .LINE_LEN(LINE_LEN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_ready(s_ready),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_data (m_data),
  .m_sof  (m_sof),
  .m_sol  (m_sol)
);

// File: tb/img_conv2d_test.sv
module img_conv2d_test;

  localparam int PW = 12, W = 12, L = 8, K = 5, CW = 12, SW = 5;
  localparam int H = (K - 1) / 2, NT = K * K, NC = (NT + 1) / 2;
  localparam int AW = $clog2(NC + 1);
  localparam int MAXP = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_sol = 1'b0, m_ready = 1'b1;
  logic [PW-1:0] s_data = '0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic s_ready, m_valid, m_sof, m_sol;
  logic [PW-1:0] m_data;

  always #10 clk = ~clk;

  img_conv2d #(.PW(PW), .LINE_LEN(W), .NUM_LINES(L), .K(K), .CW(CW), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_sol(s_sol), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_sol(m_sol), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int vectors = 0, errors = 0, cycles = 0;
  bit bp = 0, gaps = 0;
  int img [L][W];
  int shadow_w [NC];
  int shadow_s;
  int exp_q [$];
  string tag_q [$];

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference: full 2D sum with edge clamping, symmetric weight lookup.
  task automatic push_expected(input string tag);
    for (int y = 0; y < L; y++) begin
      for (int x = 0; x < W; x++) begin
        int acc, r;
        acc = 0;
        for (int dy = -H; dy <= H; dy++) begin
          for (int dx = -H; dx <= H; dx++) begin
            int yy, xx, n, a;
            yy = (y + dy < 0) ? 0 : ((y + dy > L - 1) ? L - 1 : y + dy);
            xx = (x + dx < 0) ? 0 : ((x + dx > W - 1) ? W - 1 : x + dx);
            n  = (dy + H) * K + (dx + H);
            a  = (n < NC) ? n : NT - 1 - n;
            acc += shadow_w[a] * img[yy][xx];
          end
        end
        r = (shadow_s == 0) ? acc : ((acc + (1 << (shadow_s - 1))) >>> shadow_s);
        if (r < 0) r = 0;
        if (r > MAXP) r = MAXP;
        exp_q.push_back(r | ((x == 0 && y == 0) ? (1 << 16) : 0) | ((x == 0) ? (1 << 17) : 0));
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = CW'(data);
    tick();
    cfg_we = 1'b0;
    if (addr == NC) shadow_s = data & ((1 << SW) - 1);
    else if (addr < NC) shadow_w[addr] = (data >= (1 << (CW - 1))) ? data - (1 << CW) : data;
  endtask

  task automatic send(input int pix, input bit sof, input bit sol);
    bit acc;
    if (gaps) begin
      while ($urandom % 4 == 0) tick();
    end
    s_valid = 1'b1; s_data = PW'(pix); s_sof = sof; s_sol = sol;
    do begin
      @(negedge clk);
      acc = s_valid && s_ready;
      tick();
    end while (!acc);
    s_valid = 1'b0; s_sof = 1'b0; s_sol = 1'b0;
  endtask

  // Feeds the current image; optionally rewrites weights halfway through.
  task automatic feed(input bit junk, input bit rewrite);
    if (junk) begin
      send(123, 1'b0, 1'b1);
      send(4000, 1'b0, 1'b0);
    end
    for (int y = 0; y < L; y++) begin
      for (int x = 0; x < W; x++) begin
        send(img[y][x], (x == 0 && y == 0), (x == 0) || (junk && x == 5));
        if (rewrite && y == L / 2 && x == 0) begin
          for (int a = 0; a < NC; a++) cfg_write(a, 1);
          cfg_write(NC, 3);
        end
      end
    end
  endtask

  // Output monitor, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check("R6 extra output", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(m_data), e & 16'hFFFF);
        check({t, " R6 sof"}, int'(m_sof), (e >> 16) & 1);
        check({t, " R6 sol"}, int'(m_sol), (e >> 17) & 1);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    m_ready = bp ? ($urandom % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check("watchdog", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NC; a++) shadow_w[a] = (a == NC - 1) ? 1 : 0;
    shadow_s = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset m_valid", int'(m_valid), 0);
    check("R8 reset s_ready", int'(s_ready), 1);
    tick();

    // R1: identity after reset, random pixels
    for (int y = 0; y < L; y++) for (int x = 0; x < W; x++) img[y][x] = $urandom % (MAXP + 1);
    push_expected("R1 identity");
    feed(0, 0);

    // R2 R3 R4: distinct signed weights, random image, stalls and gaps
    for (int a = 0; a < NC; a++) cfg_write(a, (a * 5 - 30) & ((1 << CW) - 1));
    cfg_write(NC, 4);
    cfg_write(NC + 1, 7);
    bp = 1; gaps = 1;
    for (int y = 0; y < L; y++) for (int x = 0; x < W; x++) img[y][x] = $urandom % (MAXP + 1);
    push_expected("R2 R4 random");
    feed(0, 0);

    // R3 R7 R5: impulse image with stray beats; weights rewritten mid-frame
    for (int y = 0; y < L; y++) for (int x = 0; x < W; x++) img[y][x] = 0;
    img[3][5] = 3000;
    img[0][W-1] = 2000;
    push_expected("R3 R7 impulse");
    feed(1, 1);

    // R5 R4: new weights from this frame on; gradient saturates
    for (int y = 0; y < L; y++) for (int x = 0; x < W; x++) img[y][x] = (x * 300 + y * 40) % (MAXP + 1);
    push_expected("R5 R4 gradient");
    feed(0, 0);

    // R2: all-max image, output in the upper clamp
    bp = 0; gaps = 0;
    for (int y = 0; y < L; y++) for (int x = 0; x < W; x++) img[y][x] = MAXP;
    push_expected("R2 R4 flat max");
    feed(0, 0);

    // Drain the pipeline
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) tick();
    check("R6 all outputs seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule